// File: doc/BRIEF.md
# Length-Decoded Serial Configuration Slave

This block is the configuration front end of a frequency-synthesizer controller. A host writes it over a three-wire serial link: an active-low select, a serial clock that idles high, and a data line. The data line is captured on each rising serial-clock edge while the select is low, most significant bit first. No address field is sent. When the select returns high, the block counts how many rising clock edges arrived during the transfer and uses that count to decide which register the data was meant for.

An 8-edge transfer writes the control register. A 16-edge transfer writes the feedback divider. A 15-edge or 24-edge transfer writes the reference divider. Transfers of 9 to 13 edges form a start-up sequence: they change no register and raise only their own strobe. Every other length is discarded.

The serial pins are brought into the system clock domain through synchronizers. A three-state machine does the sequencing. ST_IDLE waits for the select to fall; that transition clears the bit counter and shift register and moves to ST_ACTIVE. ST_ACTIVE shifts one bit on each synchronized rising serial-clock edge; the select rising moves it to ST_COMMIT. ST_COMMIT decodes the length, writes at most one register together with its one-cycle strobe, and returns to ST_IDLE unconditionally. Register contents drive parallel outputs for the divider and phase-detector logic.

Top module: `lenreg_slave`

## Requirements
- R1: A transfer of exactly 8 rising serial-clock edges loads the control register with the 8 bits received, the first bit received going to bit 7.
- R2: A transfer of exactly 16 edges loads `n_div` with the 16 bits received, the first bit received going to bit 15.
- R3: A transfer of exactly 15 edges loads `r_div` with the 15 bits received, the first bit received going to bit 14.
- R4: A transfer of exactly 24 edges loads `r_div` with the last 15 bits received; the first 9 bits are discarded whatever their value.
- R5: A transfer of 9, 10, 11, 12 or 13 edges pulses `upd_init` and leaves the control register, `n_div` and `r_div` unchanged.
- R6: A transfer of any other length (1 to 7, 14, 17 to 23, 25 or more) pulses no strobe and leaves every register unchanged. The edge counter saturates at 31, so a 40-edge transfer is discarded rather than being taken as an 8-edge one.
- R7: The control register drives its fields as follows: bit 7 `pd_invert`, bit 6 `pd_sel_tristate`, bit 5 `lock_det_en`, bits 4..2 `refout_div`, bit 1 `fv_out_en`, bit 0 `fr_out_en`.
- R8: After reset, all register outputs are zero and no strobe is active.
- R9: Serial-clock edges that occur while `cs_n` is high neither shift data nor count.
- R10: Each accepted transfer raises exactly one of `upd_ctrl`, `upd_n`, `upd_r` and `upd_init`, for exactly one system-clock cycle. That cycle is the one in which the matching register changes, after `cs_n` has risen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock, idles high |
| sdi | input | 1 | Serial data, MSB first |
| pd_invert | output | 1 | Control bit 7: phase-detector polarity |
| pd_sel_tristate | output | 1 | Control bit 6: detector output select |
| lock_det_en | output | 1 | Control bit 5: lock-detect enable |
| refout_div | output | 3 | Control bits 4..2: reference output divider code |
| fv_out_en | output | 1 | Control bit 1: feedback-divider output enable |
| fr_out_en | output | 1 | Control bit 0: reference-divider output enable |
| n_div | output | 16 | Feedback divider value |
| r_div | output | 15 | Reference divider value |
| upd_ctrl | output | 1 | Control register written this cycle |
| upd_n | output | 1 | Feedback divider written this cycle |
| upd_r | output | 1 | Reference divider written this cycle |
| upd_init | output | 1 | Start-up sequence recognised this cycle |

## Verification
The assertions assume that the serial pins are slow compared with `clk`. Each serial-clock level and each data value must be held for several system clocks, so that the synchronizers never see a serial-clock edge and a select edge in the same cycle. The assertions also assume that `cs_n` stays high long enough for ST_COMMIT to finish before the next transfer starts. The bench meets these assumptions by holding every serial-clock phase for four system clocks. It changes data only on falling serial-clock edges, waits four clocks between the select edges and the first or last clock edge, and keeps the select high for ten clocks between transfers.

// File: rtl/lenreg_pkg.sv
`timescale 1ns/1ps
package lenreg_pkg;

    localparam int CTRL_W     = 8;
    localparam int N_W        = 16;
    localparam int R_W        = 15;
    localparam int CNT_W      = 5;
    localparam int SHIFT_W    = (N_W > R_W) ? N_W : R_W;

    localparam int LEN_CTRL   = 8;
    localparam int LEN_N      = 16;
    localparam int LEN_R      = 15;
    localparam int LEN_R_LONG = 24;
    localparam int INIT_MIN   = 9;
    localparam int INIT_MAX   = 13;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACTIVE,
        ST_COMMIT
    } slave_state_t;

    typedef enum logic [2:0] {
        CLS_NONE,
        CLS_CTRL,
        CLS_N,
        CLS_R,
        CLS_INIT
    } xfer_class_t;

endpackage

// File: rtl/lenreg_sync.sv
`timescale 1ns/1ps
module lenreg_sync #(
    parameter int           W      = 3,
    parameter int           STAGES = 2,
    parameter logic [W-1:0] RST    = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= RST;
        else        stg[0] <= din;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= RST;
            else        stg[i] <= stg[i-1];
        end
    end

    assign dout = stg[STAGES-1];

endmodule

// File: rtl/lenreg_shifter.sv
`timescale 1ns/1ps
module lenreg_shifter #(
    parameter int SHIFT_W = 16,
    parameter int CNT_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               en,
    input  logic               bit_in,
    output logic [SHIFT_W-1:0] data,
    output logic [CNT_W-1:0]   count
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data  <= '0;
            count <= '0;
        end else if (clr) begin
            data  <= '0;
            count <= '0;
        end else if (en) begin
            data  <= {data[SHIFT_W-2:0], bit_in};
            if (count != CNT_MAX) count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/lenreg_decode.sv
`timescale 1ns/1ps
module lenreg_decode
    import lenreg_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic [CW-1:0] count,
    output xfer_class_t   cls
);

    always_comb begin
        if (count == CW'(LEN_CTRL))
            cls = CLS_CTRL;
        else if (count == CW'(LEN_N))
            cls = CLS_N;
        else if ((count == CW'(LEN_R)) || (count == CW'(LEN_R_LONG)))
            cls = CLS_R;
        else if ((count >= CW'(INIT_MIN)) && (count <= CW'(INIT_MAX)))
            cls = CLS_INIT;
        else
            cls = CLS_NONE;
    end

endmodule

// File: rtl/lenreg_slave.sv
`timescale 1ns/1ps
module lenreg_slave
    import lenreg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             sclk,
    input  logic             sdi,
    output logic             pd_invert,
    output logic             pd_sel_tristate,
    output logic             lock_det_en,
    output logic [2:0]       refout_div,
    output logic             fv_out_en,
    output logic             fr_out_en,
    output logic [N_W-1:0]   n_div,
    output logic [R_W-1:0]   r_div,
    output logic             upd_ctrl,
    output logic             upd_n,
    output logic             upd_r,
    output logic             upd_init
);

    localparam int PIN_CS   = 2;
    localparam int PIN_SCLK = 1;
    localparam int PIN_SDI  = 0;

    logic [2:0]         pins_s;
    logic               cs_prev, sclk_prev;
    logic               cs_rise, cs_fall, sclk_rise;
    slave_state_t       state_q, state_d;
    logic [SHIFT_W-1:0] sh_data;
    logic [CNT_W-1:0]   sh_count;
    xfer_class_t        cls;
    logic [CTRL_W-1:0]  ctrl_q;

    lenreg_sync #(.W(3), .STAGES(SYNC_STAGES), .RST(3'b110)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({cs_n, sclk, sdi}),
        .dout  (pins_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_prev   <= 1'b1;
            sclk_prev <= 1'b1;
        end else begin
            cs_prev   <= pins_s[PIN_CS];
            sclk_prev <= pins_s[PIN_SCLK];
        end
    end

    assign cs_rise   =  pins_s[PIN_CS]   & ~cs_prev;
    assign cs_fall   = ~pins_s[PIN_CS]   &  cs_prev;
    assign sclk_rise =  pins_s[PIN_SCLK] & ~sclk_prev;

    lenreg_shifter #(.SHIFT_W(SHIFT_W), .CNT_W(CNT_W)) i_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    ((state_q == ST_IDLE) && cs_fall),
        .en     ((state_q == ST_ACTIVE) && sclk_rise),
        .bit_in (pins_s[PIN_SDI]),
        .data   (sh_data),
        .count  (sh_count)
    );

    lenreg_decode #(.CW(CNT_W)) i_dec (
        .count (sh_count),
        .cls   (cls)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (cs_fall) state_d = ST_ACTIVE;
            ST_ACTIVE: if (cs_rise) state_d = ST_COMMIT;
            ST_COMMIT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs: registers and strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            n_div    <= '0;
            r_div    <= '0;
            upd_ctrl <= 1'b0;
            upd_n    <= 1'b0;
            upd_r    <= 1'b0;
            upd_init <= 1'b0;
        end else begin
            upd_ctrl <= 1'b0;
            upd_n    <= 1'b0;
            upd_r    <= 1'b0;
            upd_init <= 1'b0;
            if (state_q == ST_COMMIT) begin
                case (cls)
                    CLS_CTRL: begin
                        ctrl_q   <= sh_data[CTRL_W-1:0];
                        upd_ctrl <= 1'b1;
                    end
                    CLS_N: begin
                        n_div <= sh_data[N_W-1:0];
                        upd_n <= 1'b1;
                    end
                    CLS_R: begin
                        r_div <= sh_data[R_W-1:0];
                        upd_r <= 1'b1;
                    end
                    CLS_INIT: upd_init <= 1'b1;
                    default:  ;
                endcase
            end
        end
    end

    assign pd_invert       = ctrl_q[7];
    assign pd_sel_tristate = ctrl_q[6];
    assign lock_det_en     = ctrl_q[5];
    assign refout_div      = ctrl_q[4:2];
    assign fv_out_en       = ctrl_q[1];
    assign fr_out_en       = ctrl_q[0];

endmodule

// File: rtl/lenreg_slave_chk.sv
`timescale 1ns/1ps
module lenreg_slave_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cs_n,
    input logic [7:0]  ctrl,
    input logic [15:0] n_div,
    input logic [14:0] r_div,
    input logic        upd_ctrl,
    input logic        upd_n,
    input logic        upd_r,
    input logic        upd_init
);

    logic upd_any;
    assign upd_any = upd_ctrl | upd_n | upd_r | upd_init;

    a_r8_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ctrl == 8'h00 && n_div == 16'h0 && r_div == 15'h0 && !upd_any));

    a_r1_ctrl_only_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl) |-> upd_ctrl);

    a_r2_n_only_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(n_div) |-> upd_n);

    a_r3_r_only_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(r_div) |-> upd_r);

    a_r5_init_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        upd_init |-> ($stable(ctrl) && $stable(n_div) && $stable(r_div)));

    a_r10_strobe_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({upd_ctrl, upd_n, upd_r, upd_init}));

    a_r10_strobe_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        upd_any |=> !upd_any);

    a_r10_strobe_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        upd_any |-> cs_n);

endmodule

bind lenreg_slave lenreg_slave_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .ctrl     ({pd_invert, pd_sel_tristate, lock_det_en, refout_div, fv_out_en, fr_out_en}),
    .n_div    (n_div),
    .r_div    (r_div),
    .upd_ctrl (upd_ctrl),
    .upd_n    (upd_n),
    .upd_r    (upd_r),
    .upd_init (upd_init)
);

// File: tb/test_lenreg_slave.sv
`timescale 1ns/1ps
module test_lenreg_slave;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b1;
    logic        sdi = 1'b0;
    logic        pd_invert, pd_sel_tristate, lock_det_en, fv_out_en, fr_out_en;
    logic [2:0]  refout_div;
    logic [15:0] n_div;
    logic [14:0] r_div;
    logic        upd_ctrl, upd_n, upd_r, upd_init;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // strobe monitor: pulses and high cycles per strobe
    int pul [4];
    int hi [4];
    logic [3:0] prev_s = '0;

    always #2.5 clk = ~clk;

    lenreg_slave i_lenreg_slave (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .pd_invert(pd_invert), .pd_sel_tristate(pd_sel_tristate),
        .lock_det_en(lock_det_en), .refout_div(refout_div),
        .fv_out_en(fv_out_en), .fr_out_en(fr_out_en),
        .n_div(n_div), .r_div(r_div),
        .upd_ctrl(upd_ctrl), .upd_n(upd_n), .upd_r(upd_r), .upd_init(upd_init)
    );

    initial begin
        for (int i = 0; i < 4; i++) begin
            pul[i] = 0;
            hi[i]  = 0;
        end
    end

    always @(negedge clk) begin
        logic [3:0] s;
        s = {upd_init, upd_r, upd_n, upd_ctrl};
        for (int i = 0; i < 4; i++) begin
            if (s[i] && !prev_s[i]) pul[i] = pul[i] + 1;
            if (s[i]) hi[i] = hi[i] + 1;
        end
        prev_s = s;
    end

    function automatic logic [7:0] ctrl_now();
        return {pd_invert, pd_sel_tristate, lock_det_en, refout_div, fv_out_en, fr_out_en};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // send nbits, first bit = data[nbits-1]
    task automatic xfer(input int nbits, input logic [63:0] data);
        @(negedge clk);
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int b = nbits - 1; b >= 0; b--) begin
            sclk = 1'b0;
            sdi  = data[b];
            repeat (4) @(negedge clk);
            sclk = 1'b1;
            repeat (4) @(negedge clk);
        end
        cs_n = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    // runs a transfer and checks strobe pulses and widths against expectation
    task automatic xfer_strobes(input string req, input int nbits, input logic [63:0] data,
                                input logic [3:0] exp_mask);
        int p0 [4];
        int h0 [4];
        for (int i = 0; i < 4; i++) begin
            p0[i] = pul[i];
            h0[i] = hi[i];
        end
        xfer(nbits, data);
        for (int i = 0; i < 4; i++) begin
            chk({req, " strobe pulses R10"}, pul[i] - p0[i], {31'd0, exp_mask[i]});
            chk({req, " strobe width R10"}, hi[i] - h0[i], {31'd0, exp_mask[i]});
        end
    endtask

    task automatic t_reset();
        chk("R8 ctrl", {24'd0, ctrl_now()}, 32'h0);
        chk("R8 n_div", {16'd0, n_div}, 32'h0);
        chk("R8 r_div", {17'd0, r_div}, 32'h0);
        chk("R8 strobes", {28'd0, upd_init, upd_r, upd_n, upd_ctrl}, 32'h0);
    endtask

    task automatic t_ctrl(input logic [7:0] v);
        xfer_strobes("R1", 8, {56'd0, v}, 4'b0001);
        chk("R1 ctrl", {24'd0, ctrl_now()}, {24'd0, v});
        chk("R7 pd_invert", {31'd0, pd_invert}, {31'd0, v[7]});
        chk("R7 pd_sel_tristate", {31'd0, pd_sel_tristate}, {31'd0, v[6]});
        chk("R7 lock_det_en", {31'd0, lock_det_en}, {31'd0, v[5]});
        chk("R7 refout_div", {29'd0, refout_div}, {29'd0, v[4:2]});
        chk("R7 fv_out_en", {31'd0, fv_out_en}, {31'd0, v[1]});
        chk("R7 fr_out_en", {31'd0, fr_out_en}, {31'd0, v[0]});
    endtask

    task automatic t_n(input logic [15:0] v);
        logic [7:0]  c0 = ctrl_now();
        logic [14:0] r0 = r_div;
        xfer_strobes("R2", 16, {48'd0, v}, 4'b0010);
        chk("R2 n_div", {16'd0, n_div}, {16'd0, v});
        chk("R2 ctrl kept", {24'd0, ctrl_now()}, {24'd0, c0});
        chk("R2 r_div kept", {17'd0, r_div}, {17'd0, r0});
    endtask

    task automatic t_r15(input logic [14:0] v);
        logic [15:0] n0 = n_div;
        xfer_strobes("R3", 15, {49'd0, v}, 4'b0100);
        chk("R3 r_div", {17'd0, r_div}, {17'd0, v});
        chk("R3 n_div kept", {16'd0, n_div}, {16'd0, n0});
    endtask

    task automatic t_r24(input logic [23:0] v);
        xfer_strobes("R4", 24, {40'd0, v}, 4'b0100);
        chk("R4 r_div", {17'd0, r_div}, {17'd0, v[14:0]});
    endtask

    task automatic t_init();
        logic [7:0]  c0 = ctrl_now();
        logic [15:0] n0 = n_div;
        logic [14:0] r0 = r_div;
        for (int len = 9; len <= 13; len++) begin
            xfer_strobes("R5", len, 64'hFFFF_FFFF_FFFF_FFFF, 4'b1000);
            chk("R5 ctrl kept", {24'd0, ctrl_now()}, {24'd0, c0});
            chk("R5 n_div kept", {16'd0, n_div}, {16'd0, n0});
            chk("R5 r_div kept", {17'd0, r_div}, {17'd0, r0});
        end
    endtask

    task automatic t_ignored();
        int lens [9] = '{1, 7, 14, 17, 20, 23, 25, 31, 40};
        logic [7:0]  c0 = ctrl_now();
        logic [15:0] n0 = n_div;
        logic [14:0] r0 = r_div;
        foreach (lens[k]) begin
            xfer_strobes("R6", lens[k], 64'hA5A5_5A5A_C3C3_3C3C, 4'b0000);
            chk("R6 ctrl kept", {24'd0, ctrl_now()}, {24'd0, c0});
            chk("R6 n_div kept", {16'd0, n_div}, {16'd0, n0});
            chk("R6 r_div kept", {17'd0, r_div}, {17'd0, r0});
        end
    endtask

    task automatic t_deselected_clock();
        logic [7:0] c0 = ctrl_now();
        // edges with cs_n high: no transfer, no effect
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            sclk = 1'b0;
            sdi = i[0];
            repeat (4) @(negedge clk);
            sclk = 1'b1;
            repeat (4) @(negedge clk);
        end
        repeat (10) @(negedge clk);
        chk("R9 no strobe when deselected", {28'd0, upd_init, upd_r, upd_n, upd_ctrl}, 32'h0);
        chk("R9 ctrl kept", {24'd0, ctrl_now()}, {24'd0, c0});
        // a following 8-bit transfer must count only its own edges
        xfer_strobes("R9", 8, 64'h3C, 4'b0001);
        chk("R9 ctrl after idle edges", {24'd0, ctrl_now()}, 32'h3C);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_ctrl(8'hA5);
        t_ctrl(8'h5A);
        t_n(16'hBEEF);
        t_n(16'h0038);
        t_r15(15'h5432);
        t_r15(15'h7FFF);
        t_r24(24'h00_1234);
        t_r24(24'hFF_F0F0);
        t_init();
        t_ignored();
        t_deselected_clock();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog run did not complete actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule